// File: doc/BRIEF.md
# Base-Limit Address Relocation Checker

This block sits between a processor's load/store address path and memory. Each request carries a 24-bit logical address. The block adds a programmable base to that address to form the physical address. It then compares the relocated sum against a programmable limit. Only requests whose sum is strictly below the limit reach memory. Memory never sees a logical address directly. Protection comes from these two registers alone, with no page tables and no translation cache.

A request that fails the bound check is dropped and raises a sticky protection fault. The fault records the logical address of the offending request so that supervisory software can terminate the program. The block accepts writes to the base and limit registers, and acknowledgements of a fault, only while the privileged-mode input is high. Accepted requests leave through one registered stage, so memory sees each request one cycle after it is presented.

Top module: `base_limit_guard`

## Requirements
- R1: When reset is released, `mem_valid_o`, `fault_o` and `fault_addr_o` are zero, and base and limit are both zero, so every request made before programming faults.
- R2: A request whose sum is in range appears on the memory port in the following cycle. It carries `mem_addr_o` = base + logical address (low 24 bits), together with the request's write flag and write data.
- R3: A request faults when base + logical address is greater than or equal to the limit, including exact equality. No memory request is issued for it.
- R4: The sum is formed 25 bits wide. A sum that carries out of 24 bits always faults, even when its low 24 bits are below the limit.
- R5: `fault_o` is set in the cycle after a faulting request and stays set. `fault_addr_o` holds the logical address of the first fault, and later faults do not overwrite it.
- R6: While `fault_o` is set, no request of any kind reaches memory.
- R7: Asserting `fault_ack_i` with `priv_i` high clears `fault_o` in the next cycle. An acknowledge with `priv_i` low has no effect.
- R8: A configuration write with `priv_i` low does not change base or limit. This is observed through the addresses of later requests.
- R9: A configuration write takes effect from the next cycle on. A request presented in the same cycle as the write uses the old values.
- R10: A faulting request presented in the same cycle as a privileged acknowledge leaves `fault_o` set and loads its own logical address into `fault_addr_o`.
- R11: `cfg_sel_i` = 0 selects the base register and `cfg_sel_i` = 1 selects the limit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Privileged mode; gates configuration writes and fault acknowledge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Register select: 0 base, 1 limit |
| cfg_data_i | input | 24 | Configuration write value |
| fault_ack_i | input | 1 | Fault acknowledge |
| req_valid_i | input | 1 | Processor request valid |
| req_write_i | input | 1 | Request is a store |
| req_addr_i | input | 24 | Logical address |
| req_wdata_i | input | DATA_W | Store data |
| mem_valid_o | output | 1 | Registered memory request valid |
| mem_write_o | output | 1 | Registered store flag |
| mem_addr_o | output | 24 | Registered physical address |
| mem_wdata_o | output | DATA_W | Registered store data |
| fault_o | output | 1 | Sticky protection fault |
| fault_addr_o | output | 24 | Logical address of the captured fault |

## Verification
The bound check is driven with sums well below the limit, sums one below it, sums equal to it, and sums that carry out of 24 bits while their low bits look legal. These patterns separate a correct greater-or-equal compare from a strict compare, and a 25-bit adder from a truncated one. Fault sequences check several things: a second fault while one is pending, an in-range request while a fault is pending, an acknowledge with and without privilege, and an acknowledge that coincides with a new fault. Together they show that the captured address and the blocking behave correctly. Configuration writes are made without privilege and in the same cycle as a request, so that the write gating and the update timing appear in the physical addresses that are issued.

// File: rtl/base_limit_pkg.sv
package base_limit_pkg;

    localparam int unsigned RELOC_AW = 24;

    typedef logic [RELOC_AW-1:0] laddr_t;
    typedef logic [RELOC_AW:0]   wsum_t;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic   out_of_range;
        laddr_t phys;
    } chk_res_t;

    // Relocate and bound-check one logical address; the carry bit is kept.
    function automatic chk_res_t reloc_eval(input laddr_t base,
                                            input laddr_t limit,
                                            input laddr_t laddr);
        chk_res_t r;
        wsum_t    sum;
        sum            = {1'b0, base} + {1'b0, laddr};
        r.phys         = sum[RELOC_AW-1:0];
        r.out_of_range = (sum >= {1'b0, limit});
        return r;
    endfunction

endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
    import base_limit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     priv,
    input  logic     we,
    input  cfg_sel_e sel,
    input  laddr_t   wdata,
    output laddr_t   base,
    output laddr_t   limit
);

    logic accept;
    assign accept = we && priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            base  <= '0;
            limit <= '0;
        end else if (accept) begin
            if (sel == SEL_BASE) base  <= wdata;
            else                 limit <= wdata;
        end
    end

    // R8: unprivileged or absent writes leave both registers untouched
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        !(we && priv) |=> ($stable(base) && $stable(limit)));

    // R11: a base write never disturbs the limit and vice versa
    a_r11_base_sel: assert property (@(posedge clk) disable iff (rst)
        (we && priv && sel == SEL_BASE) |=> $stable(limit));
    a_r11_limit_sel: assert property (@(posedge clk) disable iff (rst)
        (we && priv && sel == SEL_LIMIT) |=> $stable(base));

endmodule

// File: rtl/reloc_bound_chk.sv
module reloc_bound_chk
    import base_limit_pkg::*;
(
    input  laddr_t base,
    input  laddr_t limit,
    input  laddr_t laddr,
    output laddr_t phys,
    output logic   hit_fault
);

    chk_res_t res;

    always_comb begin
        res       = reloc_eval(base, limit, laddr);
        phys      = res.phys;
        hit_fault = res.out_of_range;
    end

endmodule

// File: rtl/reloc_issue_stage.sv
module reloc_issue_stage
    import base_limit_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  laddr_t            laddr,
    input  laddr_t            phys,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit_fault,
    input  logic              ack,
    input  logic              priv,
    output logic              mem_valid,
    output logic              mem_write,
    output laddr_t            mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fault,
    output laddr_t            fault_addr
);

    logic ack_ok;
    logic new_fault;
    logic issue;

    assign ack_ok    = ack && priv;
    assign new_fault = req_valid && hit_fault;
    assign issue     = req_valid && !hit_fault && !fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_write <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_valid <= issue;
            if (issue) begin
                mem_write <= req_write;
                mem_addr  <= phys;
                mem_wdata <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault      <= 1'b0;
            fault_addr <= '0;
        end else if (new_fault && (!fault || ack_ok)) begin
            fault      <= 1'b1;
            fault_addr <= laddr;
        end else if (ack_ok) begin
            fault      <= 1'b0;
        end
    end

    // R5: pending fault without a privileged acknowledge keeps its address
    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (fault && !(ack && priv)) |=> (fault && $stable(fault_addr)));

    // R6: nothing is issued while a fault is pending
    a_r6_blocked_pending: assert property (@(posedge clk) disable iff (rst)
        fault |=> !mem_valid);

    // R7: a privileged acknowledge with no new fault clears the flag
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (fault && ack && priv && !(req_valid && hit_fault)) |=> !fault);

    // R10: a new fault coinciding with acknowledge re-arms with its own address
    a_r10_ack_refault: assert property (@(posedge clk) disable iff (rst)
        (ack && priv && req_valid && hit_fault) |=> (fault && fault_addr == $past(laddr)));

endmodule

// File: rtl/base_limit_guard.sv
module base_limit_guard
    import base_limit_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [23:0]       cfg_data_i,
    input  logic              fault_ack_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [23:0]       req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              mem_valid_o,
    output logic              mem_write_o,
    output logic [23:0]       mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              fault_o,
    output logic [23:0]       fault_addr_o
);

    laddr_t base_q;
    laddr_t limit_q;
    laddr_t phys;
    logic   hit_fault;

    reloc_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .priv  (priv_i),
        .we    (cfg_we_i),
        .sel   (cfg_sel_e'(cfg_sel_i)),
        .wdata (cfg_data_i),
        .base  (base_q),
        .limit (limit_q)
    );

    reloc_bound_chk u_chk (
        .base      (base_q),
        .limit     (limit_q),
        .laddr     (req_addr_i),
        .phys      (phys),
        .hit_fault (hit_fault)
    );

    reloc_issue_stage #(.DATA_W(DATA_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid_i),
        .req_write  (req_write_i),
        .laddr      (req_addr_i),
        .phys       (phys),
        .wdata      (req_wdata_i),
        .hit_fault  (hit_fault),
        .ack        (fault_ack_i),
        .priv       (priv_i),
        .mem_valid  (mem_valid_o),
        .mem_write  (mem_write_o),
        .mem_addr   (mem_addr_o),
        .mem_wdata  (mem_wdata_o),
        .fault      (fault_o),
        .fault_addr (fault_addr_o)
    );

    // R3: a request flagged out of range never reaches memory
    a_r3_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && hit_fault) |=> !mem_valid_o);

    // R2: an issued physical address lies strictly below the limit in force
    a_r2_below_limit: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o |-> (mem_addr_o < $past(limit_q)));

    // R4: a carry out of the 24-bit sum always faults
    a_r4_carry_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && (({1'b0, base_q} + {1'b0, req_addr_i}) > 25'h0FFFFFF))
        |=> (!mem_valid_o && fault_o));

endmodule

// File: tb/test_base_limit_guard.sv
`timescale 1ns/1ps
module test_base_limit_guard;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          priv_i, cfg_we_i, cfg_sel_i, fault_ack_i;
    logic [23:0]   cfg_data_i;
    logic          req_valid_i, req_write_i;
    logic [23:0]   req_addr_i;
    logic [DW-1:0] req_wdata_i;
    logic          mem_valid_o, mem_write_o, fault_o;
    logic [23:0]   mem_addr_o, fault_addr_o;
    logic [DW-1:0] mem_wdata_o;

    always #4 clk = ~clk;

    base_limit_guard #(.DATA_W(DW)) i_base_limit_guard (
        .clk(clk), .rst(rst), .priv_i(priv_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i), .fault_ack_i(fault_ack_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .fault_o(fault_o),
        .fault_addr_o(fault_addr_o)
    );

    typedef struct {
        logic          v;
        logic          w;
        logic [23:0]   a;
        logic [DW-1:0] d;
        logic          f;
        logic [23:0]   fa;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    logic [23:0] m_base = '0, m_limit = '0, m_faddr = '0;
    logic        m_fault = 1'b0;

    function automatic logic [DW-1:0] pat(input logic [23:0] a);
        return {8'hC3, a, 8'h5A, a} ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected outputs.
    task automatic step(input logic v, input logic w, input logic [23:0] a,
                        input logic pr, input logic we, input logic sel,
                        input logic [23:0] cd, input logic ack, input string tag);
        exp_t  e;
        logic  oor;
        logic [24:0] sum;
        @(negedge clk);
        req_valid_i = v; req_write_i = w; req_addr_i = a; req_wdata_i = pat(a);
        priv_i = pr; cfg_we_i = we; cfg_sel_i = sel; cfg_data_i = cd; fault_ack_i = ack;
        sum = {1'b0, m_base} + {1'b0, a};
        oor = (sum >= {1'b0, m_limit});
        e.v = v && !oor && !m_fault;
        e.w = w; e.a = sum[23:0]; e.d = pat(a);
        if (v && oor && (!m_fault || (ack && pr))) begin
            m_fault = 1'b1; m_faddr = a;
        end else if (ack && pr) begin
            m_fault = 1'b0;
        end
        e.f = m_fault; e.fa = m_faddr; e.tag = tag;
        if (we && pr) begin
            if (sel) m_limit = cd; else m_base = cd;
        end
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 24'h0, 0, 0, 0, 24'h0, 0, tag);
    endtask

    task automatic req(input logic w, input logic [23:0] a, input string tag);
        step(1, w, a, 0, 0, 0, 24'h0, 0, tag);
    endtask

    task automatic cfg(input logic pr, input logic sel, input logic [23:0] cd, input string tag);
        step(0, 0, 24'h0, pr, 1, sel, cd, 0, tag);
    endtask

    task automatic ack(input logic pr, input string tag);
        step(0, 0, 24'h0, pr, 0, 0, 24'h0, 1, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pops one expected item per cycle after the issuing edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic ok;
                e = q.pop_front();
                n_cmp++;
                ok = (mem_valid_o === e.v) && (fault_o === e.f) && (fault_addr_o === e.fa);
                if (e.v)
                    ok = ok && (mem_addr_o === e.a) && (mem_write_o === e.w) && (mem_wdata_o === e.d);
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b a=%h w=%0b f=%0b fa=%h, expected v=%0b a=%h w=%0b f=%0b fa=%h",
                             e.tag, mem_valid_o, mem_addr_o, mem_write_o, fault_o, fault_addr_o,
                             e.v, e.a, e.w, e.f, e.fa);
                end
            end
        end
    end

    initial begin
        #1_600_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        priv_i = 0; cfg_we_i = 0; cfg_sel_i = 0; cfg_data_i = '0; fault_ack_i = 0;
        req_valid_i = 0; req_write_i = 0; req_addr_i = '0; req_wdata_i = '0;
        repeat (3) @(negedge clk);
        // R1: outputs are zero while and right after reset
        n_cmp++;
        if (mem_valid_o !== 1'b0 || fault_o !== 1'b0 || fault_addr_o !== 24'h0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b f=%0b fa=%h, expected 0 0 000000",
                     mem_valid_o, fault_o, fault_addr_o);
        end
        rst = 1'b0;
        idle("R1");
        // R1: limit resets to zero, so the first request faults
        req(0, 24'h000005, "R1");
        // R7: acknowledge without privilege ignored, with privilege clears
        ack(0, "R7");
        idle("R7");
        ack(1, "R7");
        idle("R7");
        // R8: unprivileged writes ignored; R11: select encoding
        cfg(0, 0, 24'h000100, "R8");
        cfg(0, 1, 24'hFFFFFF, "R8");
        req(0, 24'h000010, "R8");
        ack(1, "R8");
        cfg(1, 0, 24'h001000, "R11");
        cfg(1, 1, 24'h002000, "R11");
        // R2: in-range load and store
        req(0, 24'h000000, "R2");
        req(1, 24'h000FFF, "R2");
        req(1, 24'h000ABC, "R2");
        idle("R2");
        // R9: write and request in the same cycle, then the next request
        step(1, 0, 24'h000010, 1, 1, 0, 24'h001100, 0, "R9");
        req(0, 24'h000010, "R9");
        cfg(1, 0, 24'h001000, "R9");
        // R3: sum equal to the limit faults; one below passes
        req(0, 24'h000FFF, "R3");
        req(0, 24'h001000, "R3");
        // R5: second fault keeps first address; R6: in-range blocked
        req(1, 24'h001500, "R5");
        req(0, 24'h000020, "R6");
        idle("R6");
        // R10: acknowledge together with a new fault
        step(1, 0, 24'h001800, 1, 0, 0, 24'h0, 1, "R10");
        idle("R10");
        // R6: in-range request with acknowledge still blocked
        step(1, 0, 24'h000030, 1, 0, 0, 24'h0, 1, "R6");
        req(0, 24'h000030, "R2");
        // R4: carry out of 24 bits faults
        cfg(1, 0, 24'hFFFF00, "R4");
        cfg(1, 1, 24'hFFFFFF, "R4");
        req(0, 24'h000080, "R4");
        req(0, 24'h000200, "R4");
        idle("R4");
        ack(1, "R4");
        req(1, 24'h0000FE, "R4");
        req(1, 24'h0000FF, "R4");
        ack(1, "R4");
        // R2: several in-range patterns
        cfg(1, 0, 24'h030000, "R2");
        cfg(1, 1, 24'h800000, "R2");
        for (int i = 0; i < 8; i++) begin
            req(i[0], 24'(i * 24'h012345), "R2");
            if (i == 3) idle("R2");
        end
        idle("R2");
        @(posedge clk);
        #3;
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

endmodule